// File: doc/BRIEF.md
# Bridge Power-Up Sequencer with Idle Autosuspend

This block owns the power pins of an attached display bridge. It switches the bridge's supply rails and drives its power-down and reset lines. Clients share the device through one-cycle `use_get` and `use_put` pulses, and the block keeps a usage count from them. When the count is non-zero and the device is off, the block runs a fixed resume sequence. First the rails turn on. Then power-down is released while reset is held for a programmed time. Then reset is released, followed by a long settle period. An optional wait on a hot-plug status input comes last. Only after all of that does `dev_ready` rise.

When the count falls to zero the device is not switched off at once. An idle timer runs first, and any new request inside that window cancels the pending suspend. When the timer expires, or when `force_sleep` is pulsed, the block runs the reverse order: reset first, then power-down, then the rails. The hot-plug wait gives up after a programmed limit. In that case it raises `hpd_warn` and still finishes the enable. Every delay is a parameter counted in clock ticks.

Top module: `bps_power_seq`

## Requirements
- R1: While `rst_n` is low, the rails are off, `dev_pd` and `dev_rst` are high, `dev_ready` and `hpd_warn` are low, and `use_count` is zero.
- R2: Resume starts with one cycle that has the rails on and both `dev_pd` and `dev_rst` high. Next, `dev_pd` falls while `dev_rst` stays high for exactly RST_HOLD_TICKS cycles, and then `dev_rst` falls.
- R3: After `dev_rst` falls, `dev_ready` stays low for SETTLE_TICKS cycles plus the length of the hot-plug phase.
- R4: The hot-plug phase ends on the first cycle in which `hpd_in` is seen high. If `hpd_in` is already high, the phase lasts one cycle.
- R5: If `hpd_in` stays low for HPD_LIMIT_TICKS cycles, `hpd_warn` goes high and the device still becomes ready. `hpd_warn` returns low when the next resume begins.
- R6: `dev_ready` is high only in the settled state, with all rails on and `dev_pd` and `dev_rst` low. It is low in every sequencing step.
- R7: Suspend drives one cycle with `dev_rst` high, then one cycle with `dev_pd` high too, then turns the rails off.
- R8: Once the count is zero in the ready state, `dev_ready` stays high for IDLE_TICKS cycles before suspend starts. A `use_get` inside that window cancels the suspend.
- R9: `force_sleep` clears the count. In the ready state, suspend starts on the next cycle. During resume, the sequence finishes and then suspends without `dev_ready` ever rising.
- R10: A `use_get` that arrives during suspend does not abort it. The rails go off for one cycle and then a full resume starts.
- R11: `use_get` adds one and `use_put` subtracts one. Both in the same cycle leave the count unchanged. A `use_put` at zero is ignored, and the count saturates at 2^USE_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| use_get | input | 1 | One-cycle usage request |
| use_put | input | 1 | One-cycle usage release |
| force_sleep | input | 1 | One-cycle immediate suspend request |
| hpd_in | input | 1 | Hot-plug status from the device |
| rail_en | output | RAILS | Supply rail enables, high = on |
| dev_pd | output | 1 | Power-down line, high = asserted |
| dev_rst | output | 1 | Reset line, high = asserted |
| dev_ready | output | 1 | Device powered and settled |
| hpd_warn | output | 1 | Hot-plug wait timed out during the last resume |
| use_count | output | USE_W | Current usage count |

## Verification
The assertions assume that `use_get`, `use_put` and `force_sleep` are clean single-cycle pulses, synchronous to `clk`. They also assume that `force_sleep` never coincides with a `use_get` that is meant to count. The stimulus drives every input at the falling edge and holds each pulse for exactly one cycle. It sends `force_sleep` only on its own. It raises `hpd_in` only between rising edges, so the hot-plug exit cycle is well defined.

// File: rtl/bps_pkg.sv
`timescale 1ns/1ps
package bps_pkg;

  typedef enum logic [2:0] {
    ST_OFF, ST_RAIL, ST_HOLD, ST_SETTLE, ST_HPD, ST_ON, ST_DN_RST, ST_DN_PD
  } bps_state_e;

  // A phase of `ticks` cycles is complete on its last cycle.
  function automatic logic bps_done(input logic [31:0] cnt, input logic [31:0] ticks);
    return (cnt + 32'd1) >= ticks;
  endfunction

  // Saturating usage count update; clear wins over everything.
  function automatic logic [31:0] bps_use_next(input logic [31:0] cur, input logic [31:0] top,
                                               input logic inc, input logic dec, input logic clr);
    if (clr) return 32'd0;
    if (inc && !dec) return (cur < top) ? cur + 32'd1 : cur;
    if (dec && !inc) return (cur != 32'd0) ? cur - 32'd1 : cur;
    return cur;
  endfunction

  function automatic logic [31:0] bps_max4(input logic [31:0] a, input logic [31:0] b,
                                           input logic [31:0] c, input logic [31:0] d);
    logic [31:0] m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic bps_rails_on(input bps_state_e st);
    return st != ST_OFF;
  endfunction

  function automatic logic bps_pd_level(input bps_state_e st);
    return st inside {ST_OFF, ST_RAIL, ST_DN_PD};
  endfunction

  function automatic logic bps_rst_level(input bps_state_e st);
    return st inside {ST_OFF, ST_RAIL, ST_HOLD, ST_DN_RST, ST_DN_PD};
  endfunction

endpackage

// File: rtl/bps_use_ctr.sv
`timescale 1ns/1ps
module bps_use_ctr import bps_pkg::*; #(
  parameter int unsigned USE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [USE_W-1:0] count,
  output logic             nz
);
  localparam int unsigned TOP = (1 << USE_W) - 1;

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= USE_W'(bps_use_next(32'(count), 32'(TOP), inc, dec, clr));
  end

  assign nz = |count;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == USE_W'(TOP) && inc && !dec && !clr) |=> count == USE_W'(TOP)); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && dec && !inc && !clr) |=> count == '0); // R11
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !nz); // R9
endmodule

// File: rtl/bps_tick_timer.sv
`timescale 1ns/1ps
module bps_tick_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [TW-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (clear)                count <= '0;
    else if (count != {TW{1'b1}})  count <= count + TW'(1);
  end

  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0); // R3
endmodule

// File: rtl/bps_seq_fsm.sv
`timescale 1ns/1ps
module bps_seq_fsm import bps_pkg::*; #(
  parameter int unsigned RST_HOLD_TICKS  = 110_000,
  parameter int unsigned SETTLE_TICKS    = 10_000_000,
  parameter int unsigned HPD_LIMIT_TICKS = 10_000_000,
  parameter int unsigned IDLE_TICKS      = 50_000_000,
  parameter bit          HPD_WAIT_EN     = 1'b1,
  parameter int unsigned TW              = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          users_nz,
  input  logic          use_get,
  input  logic          force_off,
  input  logic          hpd_in,
  input  logic [TW-1:0] tmr,
  output bps_state_e    state,
  output logic          tmr_clear,
  output logic          hpd_timeout,
  output logic          seq_go,
  output logic          hpd_warn
);
  bps_state_e  state_nx;
  bps_state_e  land_st;
  bps_state_e  after_settle;
  logic        force_pend;
  logic [31:0] t32;

  assign t32     = 32'(tmr);
  assign land_st = (force_pend || force_off) ? ST_DN_RST : ST_ON;

  generate
    if (HPD_WAIT_EN) begin : g_hpd
      assign after_settle = ST_HPD;
    end else begin : g_nohpd
      assign after_settle = land_st;
    end
  endgenerate

  assign hpd_timeout = (state == ST_HPD) && !hpd_in && bps_done(t32, HPD_LIMIT_TICKS);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_OFF:    if (users_nz && !force_off) state_nx = ST_RAIL;
      ST_RAIL:   state_nx = ST_HOLD;
      ST_HOLD:   if (bps_done(t32, RST_HOLD_TICKS)) state_nx = ST_SETTLE;
      ST_SETTLE: if (bps_done(t32, SETTLE_TICKS)) state_nx = after_settle;
      ST_HPD:    if (hpd_in || hpd_timeout) state_nx = land_st;
      ST_ON: begin
        if (force_off) state_nx = ST_DN_RST;
        else if (!users_nz && !use_get && bps_done(t32, IDLE_TICKS)) state_nx = ST_DN_RST;
      end
      ST_DN_RST: state_nx = ST_DN_PD;
      ST_DN_PD:  state_nx = ST_OFF;
      default:   state_nx = ST_OFF;
    endcase
  end

  assign seq_go    = (state == ST_OFF) && (state_nx == ST_RAIL);
  assign tmr_clear = (state_nx != state) || ((state == ST_ON) && (users_nz || use_get));

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= state_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                             force_pend <= 1'b0;
    else if (state_nx == ST_OFF || state_nx == ST_DN_RST)   force_pend <= 1'b0;
    else if (force_off && state inside {ST_RAIL, ST_HOLD, ST_SETTLE, ST_HPD})
                                                            force_pend <= 1'b1;
    else if (use_get)                                       force_pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           hpd_warn <= 1'b0;
    else if (seq_go)      hpd_warn <= 1'b0;
    else if (hpd_timeout) hpd_warn <= 1'b1;
  end

  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && (t32 + 32'd1) < RST_HOLD_TICKS) |=> state == ST_HOLD); // R2
  AST_HPD_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HPD && hpd_in) |=> state != ST_HPD); // R4
  AST_TIMEOUT_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    hpd_timeout |=> hpd_warn); // R5
  AST_DOWN_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DN_RST |=> state == ST_DN_PD); // R10
  AST_FORCE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (force_pend && state == ST_HPD) |=> state != ST_ON); // R9
endmodule

// File: rtl/bps_power_seq.sv
`timescale 1ns/1ps
module bps_power_seq import bps_pkg::*; #(
  parameter int unsigned RAILS           = 2,
  parameter int unsigned USE_W           = 4,
  parameter int unsigned RST_HOLD_TICKS  = 110_000,
  parameter int unsigned SETTLE_TICKS    = 10_000_000,
  parameter int unsigned HPD_LIMIT_TICKS = 10_000_000,
  parameter int unsigned IDLE_TICKS      = 50_000_000,
  parameter bit          HPD_WAIT_EN     = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_get,
  input  logic             use_put,
  input  logic             force_sleep,
  input  logic             hpd_in,
  output logic [RAILS-1:0] rail_en,
  output logic             dev_pd,
  output logic             dev_rst,
  output logic             dev_ready,
  output logic             hpd_warn,
  output logic [USE_W-1:0] use_count
);
  localparam int unsigned TICK_MAX = bps_max4(RST_HOLD_TICKS, SETTLE_TICKS,
                                              HPD_LIMIT_TICKS, IDLE_TICKS);
  localparam int unsigned TMR_W    = $clog2(TICK_MAX + 1);

  bps_state_e       state;
  logic             users_nz;
  logic             tmr_clear;
  logic             hpd_timeout;
  logic             seq_go;
  logic             rails_on;
  logic [TMR_W-1:0] tmr;

  bps_use_ctr #(.USE_W(USE_W)) u_use (
    .clk(clk), .rst_n(rst_n), .inc(use_get), .dec(use_put), .clr(force_sleep),
    .count(use_count), .nz(users_nz)
  );

  bps_tick_timer #(.TW(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clear(tmr_clear), .count(tmr)
  );

  bps_seq_fsm #(
    .RST_HOLD_TICKS(RST_HOLD_TICKS), .SETTLE_TICKS(SETTLE_TICKS),
    .HPD_LIMIT_TICKS(HPD_LIMIT_TICKS), .IDLE_TICKS(IDLE_TICKS),
    .HPD_WAIT_EN(HPD_WAIT_EN), .TW(TMR_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .users_nz(users_nz), .use_get(use_get),
    .force_off(force_sleep), .hpd_in(hpd_in), .tmr(tmr), .state(state),
    .tmr_clear(tmr_clear), .hpd_timeout(hpd_timeout), .seq_go(seq_go),
    .hpd_warn(hpd_warn)
  );

  assign rails_on  = bps_rails_on(state);
  assign dev_pd    = bps_pd_level(state);
  assign dev_rst   = bps_rst_level(state);
  assign dev_ready = (state == ST_ON);

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    assign rail_en[r] = rails_on;
  end

  AST_RAIL_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en[0]) |-> (dev_pd && dev_rst)); // R2
  AST_PD_FREE_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_pd) |-> (dev_rst && rail_en[0])); // R2
  AST_READY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ready |-> (&rail_en && !dev_pd && !dev_rst)); // R6
  AST_RST_BEFORE_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_pd) |-> (dev_rst && $past(dev_rst))); // R7
  AST_RAILS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_en[0]) |-> ($past(dev_pd) && $past(dev_rst))); // R7
  AST_FORCE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ready && force_sleep) |=> !dev_ready); // R9
  AST_GO_CLEARS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
    seq_go |=> !hpd_warn); // R5
  AST_TIMEOUT_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    hpd_timeout |-> (!dev_ready && !dev_rst)); // R5
endmodule

// File: tb/tb_bps_power_seq.sv
`timescale 1ns/1ps
module tb_bps_power_seq;
  localparam int RST_T  = 5;
  localparam int SET_T  = 8;
  localparam int HPD_T  = 6;
  localparam int IDLE_T = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       get_r = 1'b0, put_r = 1'b0, frc_r = 1'b0, hpd_r = 1'b0;
  logic [1:0] rail;
  logic       pd, rs, rdy, warn;
  logic [2:0] cnt;
  int         checks = 0;
  int         failures = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  bps_power_seq #(
    .RAILS(2), .USE_W(3), .RST_HOLD_TICKS(RST_T), .SETTLE_TICKS(SET_T),
    .HPD_LIMIT_TICKS(HPD_T), .IDLE_TICKS(IDLE_T), .HPD_WAIT_EN(1'b1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .use_get(get_r), .use_put(put_r),
    .force_sleep(frc_r), .hpd_in(hpd_r), .rail_en(rail), .dev_pd(pd),
    .dev_rst(rs), .dev_ready(rdy), .hpd_warn(warn), .use_count(cnt)
  );

  task automatic chk_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse_get();
    get_r = 1'b1; step(); get_r = 1'b0;
  endtask

  task automatic pulse_put();
    put_r = 1'b1; step(); put_r = 1'b0;
  endtask

  task automatic pulse_force();
    frc_r = 1'b1; step(); frc_r = 1'b0;
  endtask

  function automatic int pins();
    return {29'd0, rail[0], pd, rs};
  endfunction

  task automatic wait_off();
    int n = 0;
    while (rail[0] && n < 300) begin n++; step(); end
    chk_eq("R7 device reaches off", rail[0], 0);
  endtask

  task automatic do_resume(input int raise_at, input int exp_pre, input int exp_warn, input string tag);
    int n = 0;
    int h = 0;
    int s = 0;
    int bad = 0;
    pulse_get();
    while (!rail[0] && n < 50) begin n++; step(); end
    chk_eq("R2 rails on with pd and rst held", pins(), 7);
    chk_eq("R5 warn cleared at resume start", warn, 0);
    step();
    while (!pd && rs && h < 1000) begin h++; step(); end
    chk_eq("R2 reset hold length", h, RST_T);
    while (!rdy && s < 1000) begin
      s++;
      if (raise_at != 0 && s == raise_at) hpd_r = 1'b1;
      if (rs || pd || !rail[0]) bad = 1;
      step();
    end
    chk_eq(tag, s, exp_pre);
    chk_eq("R5 warn flag after resume", warn, exp_warn);
    chk_eq("R6 no pin change while settling", bad, 0);
    chk_eq("R6 ready only when clean", int'(rdy && rail == 2'b11 && !pd && !rs), 1);
  endtask

  task automatic do_idle_down();
    int n = 0;
    pulse_put();
    while (rdy && n < 1000) begin n++; step(); end
    chk_eq("R8 idle window length", n, IDLE_T);
    chk_eq("R7 reset asserted first", pins(), 5);
    step();
    chk_eq("R7 power-down second", pins(), 7);
    step();
    chk_eq("R7 rails off last", pins(), 3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) step();
    chk_eq("R1 reset pins", {rail, pd, rs, rdy, warn}, 6'b001100);
    chk_eq("R1 reset count", cnt, 0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_basic();
    hpd_r = 1'b1;
    do_resume(0, SET_T + 1, 0, "R3 settle then one hot-plug cycle");
    chk_eq("R11 count after one get", cnt, 1);
    do_idle_down();
  endtask

  task automatic t_hpd_mid();
    hpd_r = 1'b0;
    do_resume(SET_T + 2, SET_T + 2, 0, "R4 hot-plug exit on rise");
    do_idle_down();
  endtask

  task automatic t_timeout();
    hpd_r = 1'b0;
    do_resume(0, SET_T + HPD_T, 1, "R5 hot-plug timeout length");
    do_idle_down();
    hpd_r = 1'b1;
    do_resume(0, SET_T + 1, 0, "R5 resume after timeout");
  endtask

  task automatic t_cancel();
    int ok = 1;
    pulse_put();
    repeat (4) step();
    pulse_get();
    repeat (3 * IDLE_T) begin
      if (!rdy) ok = 0;
      step();
    end
    chk_eq("R8 get cancels pending suspend", ok, 1);
  endtask

  task automatic t_count();
    repeat (6) pulse_get();
    chk_eq("R11 count climbs", cnt, 7);
    pulse_get();
    chk_eq("R11 count saturates", cnt, 7);
    get_r = 1'b1; put_r = 1'b1; step(); get_r = 1'b0; put_r = 1'b0;
    chk_eq("R11 get and put together", cnt, 7);
    repeat (7) pulse_put();
    chk_eq("R11 count falls", cnt, 0);
    pulse_put();
    chk_eq("R11 put at zero ignored", cnt, 0);
    wait_off();
  endtask

  task automatic t_get_in_down();
    int n = 0;
    hpd_r = 1'b1;
    do_resume(0, SET_T + 1, 0, "R4 hot-plug high on entry");
    pulse_put();
    while (rdy && n < 1000) begin n++; step(); end
    chk_eq("R10 suspend began", pins(), 5);
    pulse_get();
    chk_eq("R10 suspend continues", pins(), 7);
    step();
    chk_eq("R10 rails off for one cycle", pins(), 3);
    step();
    chk_eq("R10 full resume starts", pins(), 7);
    n = 0;
    while (!rdy && n < 100) begin n++; step(); end
    chk_eq("R10 device ready again", rdy, 1);
    chk_eq("R10 count kept", cnt, 1);
  endtask

  task automatic t_force_on();
    pulse_force();
    chk_eq("R9 force drops ready next cycle", {28'd0, rdy, rail[0], pd, rs}, 5);
    chk_eq("R9 force clears count", cnt, 0);
    wait_off();
  endtask

  task automatic t_force_resume();
    int n = 0;
    int seen = 0;
    int stay = 1;
    pulse_get();
    while (!rail[0] && n < 50) begin n++; step(); end
    step(); step();
    pulse_force();
    n = 0;
    while (rail[0] && n < 200) begin
      n++;
      if (rdy) seen = 1;
      step();
    end
    chk_eq("R9 ready never seen after force", seen, 0);
    chk_eq("R9 rails off after forced resume", rail[0], 0);
    chk_eq("R9 count cleared", cnt, 0);
    repeat (10) begin
      if (rail[0]) stay = 0;
      step();
    end
    chk_eq("R9 stays off afterwards", stay, 1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_hpd_mid();
    t_timeout();
    t_cancel();
    t_count();
    t_get_in_down();
    t_force_on();
    t_force_resume();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule